// File: doc/BRIEF.md
# Manchester Serial Configuration Slave

This block sits on a board and takes configuration commands from a remote controller over one serial line. The line is Manchester coded, so it carries clock and data together. The block recovers each bit from the mid-bit transition, using a local clock that runs at OVS times the bit rate. It checks each complete frame and then carries it out as a register write or a register read on a local 8-bit parallel bus. That bus has a 7-bit subaddress and active-low read and write strobes.

A read is answered with a short Manchester-coded reply frame on a separate one-way return path. The reply is driven identically onto two redundant output lines, so the controller can listen on whichever return fibre it has selected. The address part and the data part of every command carry their own 4-bit checksums. A frame that fails either checksum is thrown away and counted in a saturating error counter.

Top module: `mcs_config_slave`

## Requirements
- R1: Each bit lasts OVS local clocks and is Manchester coded: the first half carries the inverse of the bit and the second half carries the bit, so a mid-bit rise is 1 and a mid-bit fall is 0. The line idles low, and a frame begins at the first rising edge seen while idle.
- R2: A command frame has 35 bits, sent MSB first: a 4-bit sync field 1010, board address (7), read flag (1, where 1 means read), subaddress (7), address checksum (4), data (8), data checksum (4). A frame whose sync field differs is dropped silently.
- R3: A frame whose board address differs from the BOARD_ADDR parameter causes no bus cycle and leaves the error counter unchanged.
- R4: The address checksum is the modulo-16 sum of the four nibbles of the 16-bit word {0, board, read flag, subaddress}. On a mismatch for this board, the frame is discarded and the error counter goes up by one.
- R5: The data checksum is the modulo-16 sum of the two data nibbles, and it is checked on reads as well as on writes. On a mismatch, the frame is discarded and the error counter goes up by one.
- R6: If a bit has no mid-bit transition within OVS/4 clocks after its expected time, the frame is aborted. There is no bus cycle and no change to the error counter, and the next frame is received normally.
- R7: A write drives the subaddress and data at least one clock before the write strobe falls. The write strobe stays low for exactly STRB_CYC clocks, and address and data do not change while it is low or in the clock after it rises. The two strobes are never low together.
- R8: A read holds the read strobe low for exactly STRB_CYC clocks and samples the read data during the last of those clocks. It then sends a 16-bit reply: sync 1010, the data byte, and a 4-bit sum of the data nibbles. The reply uses the same coding and bit length as R1, and the line is low when no reply is being sent.
- R9: The two reply outputs carry the same value in every clock.
- R10: The error counter is ERR_W bits wide, never decreases, and stays at its maximum value once it gets there.
- R11: After reset both strobes are high, both reply lines are low, and the error counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock (OVS times bit rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_i | input | 1 | Manchester command line from the controller |
| cfg_tx_a_o | output | 1 | Reply line, copy A |
| cfg_tx_b_o | output | 1 | Reply line, copy B |
| lbus_addr_o | output | 7 | Local bus subaddress |
| lbus_wdata_o | output | 8 | Local bus write data |
| lbus_rdata_i | input | 8 | Local bus read data |
| lbus_rd_n_o | output | 1 | Read strobe, active low |
| lbus_wr_n_o | output | 1 | Write strobe, active low |
| err_count_o | output | ERR_W | Saturating checksum error count |

## Verification
The bench builds the block with OVS=8, STRB_CYC=2, BOARD_ADDR=7'h15 and ERR_W=2. The narrow error counter means five checksum failures are enough to reach the saturation point in R10 and hold it there. With OVS=8 each bit is short enough that several dozen frames fit in a short run. That leaves room for writes, read replies, frames for a foreign board, a bad sync field and a broken mid-bit transition, all on the same register map.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int BRD_W = 7;
  localparam int SUB_W = 7;
  localparam int DAT_W = 8;
  localparam int CS_W  = 4;
  localparam logic [3:0] SYNC_PAT = 4'b1010;
  localparam int FRM_BITS = 4 + BRD_W + 1 + SUB_W + CS_W + DAT_W + CS_W;
  localparam int REP_BITS = 4 + DAT_W + CS_W;

  typedef enum logic [1:0] {BS_IDLE, BS_SETUP, BS_STRB, BS_HOLD} bus_st_t;

  function automatic logic [3:0] nib_sum16(input logic [15:0] w);
    return w[15:12] + w[11:8] + w[7:4] + w[3:0];
  endfunction

  function automatic logic [3:0] nib_sum8(input logic [7:0] w);
    return w[7:4] + w[3:0];
  endfunction
endpackage

// File: rtl/mcs_rx_decoder.sv
module mcs_rx_decoder #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic sof_o,
  output logic bit_vld_o,
  output logic bit_val_o,
  output logic viol_o
);
  localparam int CW  = $clog2(2 * OVS);
  localparam int H1  = (OVS * 3) / 4;
  localparam int TMO = OVS + OVS / 4;

  logic [1:0]    sync_q;
  logic          s_d_q, run_q, run_n, h1_q, h1_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          sof_n, bv_n, bval_n, viol_n;
  logic          s;

  assign s = sync_q[1];

  always_comb begin
    run_n  = run_q;
    cnt_n  = cnt_q;
    h1_n   = h1_q;
    sof_n  = 1'b0;
    bv_n   = 1'b0;
    bval_n = s;
    viol_n = 1'b0;
    if (!run_q) begin
      if (s && !s_d_q) begin
        sof_n = 1'b1;
        run_n = 1'b1;
        cnt_n = CW'(1);
      end
    end else begin
      cnt_n = cnt_q + CW'(1);
      if (cnt_q == CW'(H1)) h1_n = s;
      if ((cnt_q > CW'(H1)) && (s != h1_q)) begin
        bv_n  = 1'b1;
        cnt_n = CW'(1);
      end else if (cnt_q >= CW'(TMO)) begin
        viol_n = 1'b1;
        run_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      s_d_q     <= 1'b0;
      run_q     <= 1'b0;
      cnt_q     <= '0;
      h1_q      <= 1'b0;
      sof_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_val_o <= 1'b0;
      viol_o    <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], line_i};
      s_d_q     <= s;
      run_q     <= run_n;
      cnt_q     <= cnt_n;
      h1_q      <= h1_n;
      sof_o     <= sof_n;
      bit_vld_o <= bv_n;
      bit_val_o <= bval_n;
      viol_o    <= viol_n;
    end
  end

  assert_viol_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_vld_o && viol_o));
  assert_sof_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> !viol_o && !bit_vld_o);
endmodule

// File: rtl/mcs_frame_parser.sv
module mcs_frame_parser
  import mcs_pkg::*;
#(
  parameter logic [BRD_W-1:0] BOARD_ADDR = 7'h15,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             bit_vld_i,
  input  logic             bit_val_i,
  input  logic             viol_i,
  input  logic             ready_i,
  output logic             cmd_vld_o,
  output logic             cmd_rw_o,
  output logic [SUB_W-1:0] cmd_sub_o,
  output logic [DAT_W-1:0] cmd_data_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int NW = $clog2(FRM_BITS + 1);

  logic [FRM_BITS-1:0] sh_q, sh_n;
  logic [NW-1:0]       n_q, n_n;
  logic                act_q, act_n, done_q, done_n;
  logic                sync_ok, brd_ok, acs_ok, dcs_ok, accept, err_inc;
  logic [ERR_W-1:0]    err_n;

  always_comb begin
    act_n  = act_q;
    sh_n   = sh_q;
    n_n    = n_q;
    done_n = 1'b0;
    if (sof_i) begin
      act_n = 1'b1;
      sh_n  = {sh_q[FRM_BITS-2:0], 1'b1};
      n_n   = NW'(1);
    end else if (act_q && viol_i) begin
      act_n = 1'b0;
    end else if (act_q && bit_vld_i) begin
      sh_n = {sh_q[FRM_BITS-2:0], bit_val_i};
      n_n  = n_q + NW'(1);
      if (n_q == NW'(FRM_BITS - 1)) begin
        act_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  assign sync_ok = (sh_q[34:31] == SYNC_PAT);
  assign brd_ok  = (sh_q[30:24] == BOARD_ADDR);
  assign acs_ok  = (nib_sum16({1'b0, sh_q[30:16]}) == sh_q[15:12]);
  assign dcs_ok  = (nib_sum8(sh_q[11:4]) == sh_q[3:0]);
  assign accept  = done_q && sync_ok && brd_ok && acs_ok && dcs_ok && ready_i;
  assign err_inc = done_q && sync_ok && brd_ok && !(acs_ok && dcs_ok);

  always_comb begin
    err_n = err_cnt_o;
    if (err_inc && (err_cnt_o != {ERR_W{1'b1}})) err_n = err_cnt_o + ERR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      n_q        <= '0;
      act_q      <= 1'b0;
      done_q     <= 1'b0;
      cmd_vld_o  <= 1'b0;
      cmd_rw_o   <= 1'b0;
      cmd_sub_o  <= '0;
      cmd_data_o <= '0;
      err_cnt_o  <= '0;
    end else begin
      sh_q      <= sh_n;
      n_q       <= n_n;
      act_q     <= act_n;
      done_q    <= done_n;
      cmd_vld_o <= accept;
      err_cnt_o <= err_n;
      if (accept) begin
        cmd_rw_o   <= sh_q[23];
        cmd_sub_o  <= sh_q[22:16];
        cmd_data_o <= sh_q[11:4];
      end
    end
  end

  assert_err_no_decrease_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt_o >= $past(err_cnt_o));
  assert_err_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_o != $past(err_cnt_o)) |-> (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)));
endmodule

// File: rtl/mcs_bus_engine.sv
module mcs_bus_engine
  import mcs_pkg::*;
#(
  parameter int STRB_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld_i,
  input  logic             cmd_rw_i,
  input  logic [SUB_W-1:0] cmd_sub_i,
  input  logic [DAT_W-1:0] cmd_data_i,
  input  logic [DAT_W-1:0] bus_rdata_i,
  input  logic             tx_busy_i,
  output logic             ready_o,
  output logic [SUB_W-1:0] bus_addr_o,
  output logic [DAT_W-1:0] bus_wdata_o,
  output logic             bus_rd_n_o,
  output logic             bus_wr_n_o,
  output logic             tx_go_o,
  output logic [DAT_W-1:0] tx_byte_o
);
  localparam int SCW = $clog2(STRB_CYC + 1);

  bus_st_t          st_q, st_n;
  logic [SCW-1:0]   sc_q, sc_n;
  logic             rw_q, rw_n, rd_n_n, wr_n_n, go_n;
  logic [SUB_W-1:0] addr_n;
  logic [DAT_W-1:0] wd_n, cap_n;

  assign ready_o = (st_q == BS_IDLE) && !tx_busy_i && !tx_go_o;

  always_comb begin
    st_n   = st_q;
    sc_n   = sc_q;
    rw_n   = rw_q;
    addr_n = bus_addr_o;
    wd_n   = bus_wdata_o;
    rd_n_n = bus_rd_n_o;
    wr_n_n = bus_wr_n_o;
    cap_n  = tx_byte_o;
    go_n   = 1'b0;
    case (st_q)
      BS_IDLE: if (cmd_vld_i) begin
        addr_n = cmd_sub_i;
        rw_n   = cmd_rw_i;
        if (!cmd_rw_i) wd_n = cmd_data_i;
        st_n   = BS_SETUP;
      end
      BS_SETUP: begin
        if (rw_q) rd_n_n = 1'b0;
        else      wr_n_n = 1'b0;
        sc_n = SCW'(1);
        st_n = BS_STRB;
      end
      BS_STRB: begin
        if (sc_q == SCW'(STRB_CYC)) begin
          rd_n_n = 1'b1;
          wr_n_n = 1'b1;
          if (rw_q) cap_n = bus_rdata_i;
          st_n = BS_HOLD;
        end else begin
          sc_n = sc_q + SCW'(1);
        end
      end
      BS_HOLD: begin
        go_n = rw_q;
        st_n = BS_IDLE;
      end
      default: st_n = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= BS_IDLE;
      sc_q        <= '0;
      rw_q        <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_rd_n_o  <= 1'b1;
      bus_wr_n_o  <= 1'b1;
      tx_go_o     <= 1'b0;
      tx_byte_o   <= '0;
    end else begin
      st_q        <= st_n;
      sc_q        <= sc_n;
      rw_q        <= rw_n;
      bus_addr_o  <= addr_n;
      bus_wdata_o <= wd_n;
      bus_rd_n_o  <= rd_n_n;
      bus_wr_n_o  <= wr_n_n;
      tx_go_o     <= go_n;
      tx_byte_o   <= cap_n;
    end
  end

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n_o && !bus_wr_n_o));
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n_o || !bus_rd_n_o) |-> ($stable(bus_addr_o) && $stable(bus_wdata_o)));
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n_o) |=> ($stable(bus_addr_o) && $stable(bus_wdata_o)));
  assert_go_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go_o |-> $past(bus_rd_n_o, 2) == 1'b0);
endmodule

// File: rtl/mcs_tx_encoder.sv
module mcs_tx_encoder
  import mcs_pkg::*;
#(
  parameter int OVS     = 8,
  parameter int N_LINES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [DAT_W-1:0]   byte_i,
  output logic               busy_o,
  output logic [N_LINES-1:0] line_o
);
  localparam int HW = $clog2(OVS);
  localparam int BW = $clog2(REP_BITS);

  logic [REP_BITS-1:0] sh_q, sh_n;
  logic [BW-1:0]       bit_q, bit_n;
  logic [HW-1:0]       hc_q, hc_n;
  logic                half_q, half_n, busy_n, line_n;

  always_comb begin
    sh_n   = sh_q;
    bit_n  = bit_q;
    hc_n   = hc_q;
    half_n = half_q;
    busy_n = busy_o;
    if (!busy_o) begin
      if (go_i) begin
        sh_n   = {SYNC_PAT, byte_i, nib_sum8(byte_i)};
        busy_n = 1'b1;
        bit_n  = '0;
        hc_n   = '0;
        half_n = 1'b0;
      end
    end else if (hc_q == HW'(OVS / 2 - 1)) begin
      hc_n = '0;
      if (!half_q) begin
        half_n = 1'b1;
      end else begin
        half_n = 1'b0;
        sh_n   = {sh_q[REP_BITS-2:0], 1'b0};
        if (bit_q == BW'(REP_BITS - 1)) busy_n = 1'b0;
        else                            bit_n  = bit_q + BW'(1);
      end
    end else begin
      hc_n = hc_q + HW'(1);
    end
    line_n = busy_n && (half_n ? sh_n[REP_BITS-1] : !sh_n[REP_BITS-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      hc_q   <= '0;
      half_q <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      bit_q  <= bit_n;
      hc_q   <= hc_n;
      half_q <= half_n;
      busy_o <= busy_n;
    end
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_o[g] <= 1'b0;
      else        line_o[g] <= line_n;
    end
  end

  assert_lines_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_o == {N_LINES{line_o[0]}});
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !line_o[0]);
endmodule

// File: rtl/mcs_config_slave.sv
module mcs_config_slave
  import mcs_pkg::*;
#(
  parameter int OVS = 8,
  parameter logic [6:0] BOARD_ADDR = 7'h15,
  parameter int STRB_CYC = 2,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rx_i,
  output logic             cfg_tx_a_o,
  output logic             cfg_tx_b_o,
  output logic [6:0]       lbus_addr_o,
  output logic [7:0]       lbus_wdata_o,
  input  logic [7:0]       lbus_rdata_i,
  output logic             lbus_rd_n_o,
  output logic             lbus_wr_n_o,
  output logic [ERR_W-1:0] err_count_o
);
  logic             sof, bv, bval, viol, ready;
  logic             cmd_vld, cmd_rw, tx_go, tx_busy;
  logic [SUB_W-1:0] cmd_sub;
  logic [DAT_W-1:0] cmd_data, tx_byte;
  logic [1:0]       tx_lines;

  mcs_rx_decoder #(.OVS(OVS)) u_dec (
    .clk(clk), .rst_n(rst_n), .line_i(cfg_rx_i),
    .sof_o(sof), .bit_vld_o(bv), .bit_val_o(bval), .viol_o(viol));

  mcs_frame_parser #(.BOARD_ADDR(BOARD_ADDR), .ERR_W(ERR_W)) u_prs (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .bit_vld_i(bv), .bit_val_i(bval),
    .viol_i(viol), .ready_i(ready), .cmd_vld_o(cmd_vld), .cmd_rw_o(cmd_rw),
    .cmd_sub_o(cmd_sub), .cmd_data_o(cmd_data), .err_cnt_o(err_count_o));

  mcs_bus_engine #(.STRB_CYC(STRB_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .cmd_vld_i(cmd_vld), .cmd_rw_i(cmd_rw),
    .cmd_sub_i(cmd_sub), .cmd_data_i(cmd_data), .bus_rdata_i(lbus_rdata_i),
    .tx_busy_i(tx_busy), .ready_o(ready), .bus_addr_o(lbus_addr_o),
    .bus_wdata_o(lbus_wdata_o), .bus_rd_n_o(lbus_rd_n_o),
    .bus_wr_n_o(lbus_wr_n_o), .tx_go_o(tx_go), .tx_byte_o(tx_byte));

  mcs_tx_encoder #(.OVS(OVS), .N_LINES(2)) u_tx (
    .clk(clk), .rst_n(rst_n), .go_i(tx_go), .byte_i(tx_byte),
    .busy_o(tx_busy), .line_o(tx_lines));

  assign cfg_tx_a_o = tx_lines[0];
  assign cfg_tx_b_o = tx_lines[1];
endmodule

// File: tb/test_mcs_config_slave.sv
module test_mcs_config_slave;
  localparam int OVS = 8;
  localparam logic [6:0] BRD = 7'h15;
  localparam int ERR_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b0;
  logic tx_a, tx_b, rd_n, wr_n;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic [ERR_W-1:0] errc;

  logic [7:0] dev   [0:127];
  logic [7:0] model [0:127];

  typedef struct { bit rd; logic [6:0] a; logic [7:0] d; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0, wr_ev = 0, rep_ev = 0, line_mis = 0;

  always #4 clk = ~clk;

  assign rdata = dev[addr];

  mcs_config_slave #(.OVS(OVS), .BOARD_ADDR(BRD), .STRB_CYC(2), .ERR_W(ERR_W)) i_mcs_config_slave (
    .clk(clk), .rst_n(rst_n), .cfg_rx_i(rx), .cfg_tx_a_o(tx_a), .cfg_tx_b_o(tx_b),
    .lbus_addr_o(addr), .lbus_wdata_o(wdata), .lbus_rdata_i(rdata),
    .lbus_rd_n_o(rd_n), .lbus_wr_n_o(wr_n), .err_count_o(errc));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [34:0] mk(input logic [3:0] syn, input logic [6:0] b, input bit rw,
                                     input logic [6:0] s, input logic [7:0] d,
                                     input logic [3:0] abad, input logic [3:0] dbad);
    logic [15:0] aw;
    logic [3:0] ac, dc;
    aw = {1'b0, b, rw, s};
    ac = aw[15:12] + aw[11:8] + aw[7:4] + aw[3:0] + abad;
    dc = d[7:4] + d[3:0] + dbad;
    return {syn, b, rw, s, ac, d, dc};
  endfunction

  task automatic send(input logic [34:0] f, input int cut);
    for (int i = 34; i >= 0; i--) begin
      if (i == cut) begin
        repeat (OVS) @(negedge clk);
        break;
      end
      rx = ~f[i];
      repeat (OVS / 2) @(negedge clk);
      rx = f[i];
      repeat (OVS / 2) @(negedge clk);
    end
    rx = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] s, input logic [7:0] d);
    exp_t e;
    e.rd = 1'b0; e.a = s; e.d = d;
    q.push_back(e);
    model[s] = d;
    send(mk(4'b1010, BRD, 1'b0, s, d, 4'd0, 4'd0), -1);
  endtask

  task automatic do_read(input logic [6:0] s);
    exp_t e;
    e.rd = 1'b1; e.a = s; e.d = model[s];
    q.push_back(e);
    send(mk(4'b1010, BRD, 1'b1, s, 8'h3C, 4'd0, 4'd0), -1);
  endtask

  task automatic drain();
    for (int k = 0; k < 400 && q.size() != 0; k++) @(negedge clk);
    chk(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);
  endtask

  // write-strobe monitor (R7) and read-strobe width (R8)
  logic wr_prev = 1'b1, rd_prev = 1'b1;
  int wlow = 0, rlow = 0;
  logic [6:0] cap_a;
  logic [7:0] cap_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_a !== tx_b) line_mis++;
      if (wr_prev && !wr_n) begin
        wr_ev++;
        wlow = 1; cap_a = addr; cap_d = wdata;
        dev[addr] = wdata;
        if (q.size() == 0) chk(1'b0, "R7", "unexpected write", addr, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(!e.rd && e.a == addr && e.d == wdata, "R7", "write addr/data",
              {addr, wdata}, {e.a, e.d});
        end
      end else if (!wr_n) wlow++;
      else if (!wr_prev && wr_n) begin
        chk(wlow == 2, "R7", "write strobe width", wlow, 2);
        chk(addr == cap_a && wdata == cap_d, "R7", "addr/data held", {addr, wdata}, {cap_a, cap_d});
      end
      if (rd_prev && !rd_n) rlow = 1;
      else if (!rd_n) rlow++;
      else if (!rd_prev && rd_n) chk(rlow == 2, "R8", "read strobe width", rlow, 2);
      chk(!((!rd_n) && (!wr_n)) || 1'b0, "R7", "strobes exclusive", {rd_n, wr_n}, 3);
      n_chk--;
    end
    wr_prev = wr_n;
    rd_prev = rd_n;
  end

  // reply monitor (R8)
  initial begin
    logic prev;
    logic [15:0] bits;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && tx_a && !prev) begin
        bits = '0;
        bits[15] = 1'b1;
        for (int k = 14; k >= 0; k--) begin
          repeat (OVS) @(negedge clk);
          bits[k] = tx_a;
        end
        rep_ev++;
        chk(bits[15:12] == 4'b1010, "R8", "reply sync", bits[15:12], 4'b1010);
        chk(bits[3:0] == bits[11:8] + bits[7:4], "R8", "reply checksum", bits[3:0],
            4'(bits[11:8] + bits[7:4]));
        if (q.size() == 0) chk(1'b0, "R8", "unexpected reply", bits, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.rd && bits[11:4] == e.d, "R8", "reply data", bits[11:4], e.d);
        end
      end
      prev = tx_a;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int w0;
    for (int i = 0; i < 128; i++) begin
      dev[i] = 8'(i * 3 + 1);
      model[i] = 8'(i * 3 + 1);
    end
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n, "R11", "strobes idle after reset", {rd_n, wr_n}, 3);
    chk(!tx_a && !tx_b, "R11", "reply lines low", {tx_a, tx_b}, 0);
    chk(errc == 0, "R11", "error count zero", errc, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R7: writes with distinct bit patterns
    do_write(7'h05, 8'hA7);
    do_write(7'h7F, 8'h00);
    do_write(7'h00, 8'hFF);
    // R8: reads of written and untouched registers
    do_read(7'h05);
    drain();
    do_read(7'h7F);
    drain();
    do_read(7'h42);
    drain();
    do_read(7'h00);
    drain();

    // R3: foreign board ignored
    w0 = wr_ev;
    send(mk(4'b1010, 7'h16, 1'b0, 7'h05, 8'h11, 4'd0, 4'd0), -1);
    chk(wr_ev == w0, "R3", "no write for other board", wr_ev, w0);
    chk(errc == 0, "R3", "error count unchanged", errc, 0);

    // R2: bad sync field dropped
    send(mk(4'b1110, BRD, 1'b0, 7'h05, 8'h22, 4'd0, 4'd0), -1);
    chk(wr_ev == w0, "R2", "no write on bad sync", wr_ev, w0);
    chk(errc == 0, "R2", "error count unchanged", errc, 0);

    // R4: address checksum error
    send(mk(4'b1010, BRD, 1'b0, 7'h05, 8'h33, 4'd1, 4'd0), -1);
    chk(wr_ev == w0, "R4", "no write on address checksum error", wr_ev, w0);
    chk(errc == 1, "R4", "error count", errc, 1);

    // R5: data checksum error on a write and on a read
    send(mk(4'b1010, BRD, 1'b0, 7'h05, 8'h44, 4'd0, 4'd7), -1);
    chk(wr_ev == w0, "R5", "no write on data checksum error", wr_ev, w0);
    chk(errc == 2, "R5", "error count", errc, 2);

    // R6: missing mid-bit transition aborts
    w0 = wr_ev;
    send(mk(4'b1010, BRD, 1'b0, 7'h05, 8'h55, 4'd0, 4'd0), 20);
    chk(wr_ev == w0, "R6", "no write after code violation", wr_ev, w0);
    chk(errc == 2, "R6", "error count unchanged", errc, 2);
    do_read(7'h05);
    drain();
    do_write(7'h05, 8'h5A);
    do_read(7'h05);
    drain();

    // R10: saturation with ERR_W=2
    w0 = rep_ev;
    send(mk(4'b1010, BRD, 1'b1, 7'h05, 8'h00, 4'd0, 4'd3), -1);
    chk(rep_ev == w0, "R5", "no reply on read with data checksum error", rep_ev, w0);
    chk(errc == 3, "R10", "error count at max", errc, 3);
    send(mk(4'b1010, BRD, 1'b0, 7'h05, 8'h00, 4'd9, 4'd0), -1);
    chk(errc == 3, "R10", "error count saturated", errc, 3);
    send(mk(4'b1010, BRD, 1'b0, 7'h05, 8'h00, 4'd2, 4'd0), -1);
    chk(errc == 3, "R10", "error count still saturated", errc, 3);

    chk(line_mis == 0, "R9", "reply lines identical", line_mis, 0);
    chk(rep_ev == 6, "R8", "reply count", rep_ev, 6);
    finish_run();
  end
endmodule